// File: doc/BRIEF.md
# Streaming Core Data Flow Controller

This block is the glue between a streaming compute core and two FIFO-style links. Words arrive on an input link that reports when it holds data. They pass straight through to the core whenever the core can take one. Results the core marks valid go straight out to an output link whenever that link has room. Link transfers are combinational handshakes, so a word can move in on the same cycle it is offered. A read and a write can also happen in the same cycle.

A small five-state sequencer records what happened in the previous cycle: idle, a read, a read together with a write, a write, or a stall caused by downstream backpressure. This history, together with the live inputs, decides whether the core's clock enable and start are driven. When the output link is full, the core is frozen and no new input is taken. This means no result can be produced that has nowhere to go. After a word has been accepted, the core keeps its enable for one more cycle, so it can advance that word even when nothing else is offered.

Top module: `stream_flow_ctrl`

## Requirements
- R1: While rst_n is low, in_rd_en, out_wr_en, core_ce and core_start are all 0, whatever the other inputs are. The sequencer returns to its idle state.
- R2: in_rd_en is 1 in exactly those cycles where in_rdy, core_rfd and out_rdy are 1 and core_done is 0. core_din always equals in_data.
- R3: When core_done is 1, no read takes place, even if input data is present and core_rfd is 1.
- R4: out_wr_en is 1 in exactly those cycles where core_dv and out_rdy are 1. out_data always equals core_dout.
- R5: When a read and a write are both possible, both enables are 1 in the same cycle. The sequencer then records the combined read-write state.
- R6: Whenever out_rdy is 0, core_ce, core_start, in_rd_en and out_wr_en are 0 in that cycle. The sequencer enters its stall state at the next edge.
- R7: With out_rdy at 1, core_ce is 1 when in_rdy or core_dv is 1. core_start always equals core_ce.
- R8: In the cycle after a read, core_ce stays 1 if out_rdy is 1, even when in_rdy and core_dv are both 0. This covers both a plain read and a combined read-write.
- R9: When the previous cycle made no read, and in_rdy and core_dv are 0, core_ce is 0. This also applies when valid data has just dropped after a write.
- R10: In the first cycle out_rdy returns to 1 after a stall, a pending input word is read and core_ce is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_rdy | input | 1 | Input link holds a word |
| in_data | input | DATA_W | Word at the head of the input link |
| in_rd_en | output | 1 | Pop one word from the input link |
| core_din | output | DATA_W | Word handed to the core |
| core_rfd | input | 1 | Core ready for data |
| core_done | input | 1 | Core finished, accepts no more input |
| core_dv | input | 1 | Core result valid |
| core_dout | input | DATA_W | Core result |
| core_ce | output | 1 | Core clock enable |
| core_start | output | 1 | Core start |
| out_rdy | input | 1 | Output link can accept a word |
| out_data | output | DATA_W | Word pushed to the output link |
| out_wr_en | output | 1 | Push one word into the output link |

## Verification
The enables, core_din and out_data are due in the same cycle as the inputs that cause them. The bench therefore drives each stimulus just after a rising edge and compares at the following falling edge. The influence of the recorded state is due exactly one edge later. That applies to the extra enable cycle after a read, the quiet cycle after idle, and the recovery from stall. The bench covers these with consecutive steps whose expectations are queued in drive order and popped one per cycle. This way each comparison falls in the cycle its requirement names.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_RDWR  = 3'd2,
    ST_WRITE = 3'd3,
    ST_STALL = 3'd4
  } flow_state_t;

  // Next recorded state from this cycle's activity.
  function automatic flow_state_t f_next_state(input logic dn_ok,
                                               input logic rd,
                                               input logic wr);
    flow_state_t ns;
    if (!dn_ok)        ns = ST_STALL;
    else if (rd && wr) ns = ST_RDWR;
    else if (rd)       ns = ST_READ;
    else if (wr)       ns = ST_WRITE;
    else               ns = ST_IDLE;
    return ns;
  endfunction

  // Core runs when downstream has room and there is work to do.
  function automatic logic f_core_go(input logic        dn_ok,
                                     input logic        src_avail,
                                     input logic        res_valid,
                                     input flow_state_t st);
    logic just_fed;
    just_fed = (st == ST_READ) || (st == ST_RDWR);
    return dn_ok && (src_avail || res_valid || just_fed);
  endfunction

endpackage

// File: rtl/sfc_fire.sv
module sfc_fire (
  input  logic rst_n,
  input  logic in_rdy,
  input  logic core_rfd,
  input  logic core_done,
  input  logic core_dv,
  input  logic out_rdy,
  output logic rd_fire,
  output logic wr_fire
);

  always_comb begin
    rd_fire = rst_n && in_rdy && core_rfd && !core_done && out_rdy;
    wr_fire = rst_n && core_dv && out_rdy;
  end

endmodule

// File: rtl/sfc_seq.sv
module sfc_seq
  import sfc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        out_rdy,
  input  logic        rd_fire,
  input  logic        wr_fire,
  output flow_state_t state
);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= f_next_state(out_rdy, rd_fire, wr_fire);
  end

  AST_STALL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_rdy |=> (state == ST_STALL)); // R6
  AST_RDWR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && wr_fire) |=> (state == ST_RDWR)); // R5

endmodule

// File: rtl/sfc_core_gate.sv
module sfc_core_gate
  import sfc_pkg::*;
(
  input  logic        rst_n,
  input  logic        out_rdy,
  input  logic        in_rdy,
  input  logic        core_dv,
  input  flow_state_t state,
  output logic        core_ce,
  output logic        core_start
);

  logic go;

  always_comb begin
    go         = rst_n && f_core_go(out_rdy, in_rdy, core_dv, state);
    core_ce    = go;
    core_start = go;
  end

endmodule

// File: rtl/stream_flow_ctrl.sv
module stream_flow_ctrl
  import sfc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_rdy,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_rd_en,
  output logic [DATA_W-1:0] core_din,
  input  logic              core_rfd,
  input  logic              core_done,
  input  logic              core_dv,
  input  logic [DATA_W-1:0] core_dout,
  output logic              core_ce,
  output logic              core_start,
  input  logic              out_rdy,
  output logic [DATA_W-1:0] out_data,
  output logic              out_wr_en
);

  logic        rd_fire;
  logic        wr_fire;
  flow_state_t state;

  sfc_fire i_fire (
    .rst_n     (rst_n),
    .in_rdy    (in_rdy),
    .core_rfd  (core_rfd),
    .core_done (core_done),
    .core_dv   (core_dv),
    .out_rdy   (out_rdy),
    .rd_fire   (rd_fire),
    .wr_fire   (wr_fire)
  );

  sfc_seq i_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .out_rdy (out_rdy),
    .rd_fire (rd_fire),
    .wr_fire (wr_fire),
    .state   (state)
  );

  sfc_core_gate i_gate (
    .rst_n      (rst_n),
    .out_rdy    (out_rdy),
    .in_rdy     (in_rdy),
    .core_dv    (core_dv),
    .state      (state),
    .core_ce    (core_ce),
    .core_start (core_start)
  );

  always_comb begin
    in_rd_en  = rd_fire;
    out_wr_en = wr_fire;
    core_din  = in_data;
    out_data  = core_dout;
  end

  AST_READ_HOLDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rd_en && out_rdy) |=> (!out_rdy || core_ce)); // R8
  AST_NO_READ_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    in_rd_en |-> !core_done); // R3
  AST_WR_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr_en |-> (core_dv && out_rdy)); // R4
  AST_START_WITH_CE: assert property (@(posedge clk) disable iff (!rst_n)
    core_start == core_ce); // R7
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STALL && !out_rdy) |-> (!core_ce && !in_rd_en)); // R6

endmodule

// File: tb/test_stream_flow_ctrl.sv
module test_stream_flow_ctrl;

  localparam int DATA_W = 32;

  typedef struct {
    logic rd;
    logic wr;
    logic ce;
    logic [DATA_W-1:0] din;
    logic [DATA_W-1:0] dout;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_rdy = 1'b0, core_rfd = 1'b0, core_done = 1'b0, core_dv = 1'b0, out_rdy = 1'b0;
  logic [DATA_W-1:0] in_data = '0, core_dout = '0;
  logic in_rd_en, out_wr_en, core_ce, core_start;
  logic [DATA_W-1:0] core_din, out_data;

  int n_cmp = 0;
  int n_bad = 0;
  int step_no = 0;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  stream_flow_ctrl #(.DATA_W(DATA_W)) i_stream_flow_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_rdy(in_rdy), .in_data(in_data), .in_rd_en(in_rd_en), .core_din(core_din),
    .core_rfd(core_rfd), .core_done(core_done), .core_dv(core_dv), .core_dout(core_dout),
    .core_ce(core_ce), .core_start(core_start),
    .out_rdy(out_rdy), .out_data(out_data), .out_wr_en(out_wr_en)
  );

  task automatic chk(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] expv,
                     input string what, input string tag);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue what must be seen.
  task automatic step(input logic rst, input logic ir, input logic rfd, input logic dn,
                      input logic dv, input logic orr,
                      input logic e_rd, input logic e_wr, input logic e_ce, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    step_no++;
    rst_n     = rst;
    in_rdy    = ir;
    core_rfd  = rfd;
    core_done = dn;
    core_dv   = dv;
    out_rdy   = orr;
    in_data   = 32'hA000_0000 + 32'(step_no * 7);
    core_dout = 32'h5000_0000 + 32'(step_no * 13);
    e.rd = e_rd; e.wr = e_wr; e.ce = e_ce;
    e.din = in_data; e.dout = core_dout; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compare at the falling edge of the cycle driven.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(DATA_W'(in_rd_en),  DATA_W'(e.rd), "in_rd_en",  e.tag);
      chk(DATA_W'(out_wr_en), DATA_W'(e.wr), "out_wr_en", e.tag);
      chk(DATA_W'(core_ce),   DATA_W'(e.ce), "core_ce",   e.tag);
      chk(DATA_W'(core_start), DATA_W'(e.ce), "core_start", "R7");
      if (e.rd) chk(core_din, e.din, "core_din", "R2");
      if (e.wr) chk(out_data, e.dout, "out_data", "R4");
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    //    rst ir rfd dn dv or   rd wr ce
    step(0, 1, 1, 0, 1, 1,  0, 0, 0, "R1");
    step(0, 1, 1, 0, 1, 1,  0, 0, 0, "R1");
    step(1, 0, 0, 0, 0, 1,  0, 0, 0, "R9");
    step(1, 1, 1, 0, 0, 1,  1, 0, 1, "R2");
    step(1, 0, 0, 0, 0, 1,  0, 0, 1, "R8");
    step(1, 0, 0, 0, 0, 1,  0, 0, 0, "R9");
    step(1, 1, 1, 1, 0, 1,  0, 0, 1, "R3");
    step(1, 1, 0, 0, 0, 1,  0, 0, 1, "R2");
    step(1, 0, 0, 0, 1, 1,  0, 1, 1, "R4");
    step(1, 0, 0, 0, 0, 1,  0, 0, 0, "R9");
    step(1, 1, 1, 0, 1, 1,  1, 1, 1, "R5");
    step(1, 0, 0, 0, 0, 1,  0, 0, 1, "R8");
    step(1, 1, 1, 0, 1, 0,  0, 0, 0, "R6");
    step(1, 1, 1, 0, 0, 0,  0, 0, 0, "R6");
    step(1, 1, 1, 0, 0, 1,  1, 0, 1, "R10");
    step(1, 1, 0, 0, 1, 1,  0, 1, 1, "R4");
    step(1, 1, 1, 0, 0, 1,  1, 0, 1, "R2");
    step(1, 0, 0, 0, 0, 0,  0, 0, 0, "R6");
    step(1, 0, 0, 0, 1, 1,  0, 1, 1, "R7");
    step(1, 0, 0, 0, 0, 1,  0, 0, 0, "R9");
    step(0, 1, 1, 0, 1, 1,  0, 0, 0, "R1");
    step(1, 0, 0, 0, 0, 1,  0, 0, 0, "R1");
    @(posedge clk);
    @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule